// File: doc/BRIEF.md
# Host Shared-RAM Bus Port

This block is the slave side of a 16-bit host processor bus. Through it the host reads and writes a word-wide internal shared RAM and a small bank of registers. A built-in protocol engine also uses the same single-port RAM. The host starts a cycle by driving an active-low strobe. It steers the cycle to RAM or to the registers with a memory/register select line. The direction comes from a read/write line, and a strap fixes the sense of that line. In handshaked mode the host holds the strobe and waits for a one-clock ready pulse. In zero-wait mode the block never raises ready, and the host only has to keep the strobe low for three clocks.

An address-latch input supports hosts that share address and data on one set of wires. While the latch input is high, the address passes straight through. While it is low, the block uses the last address it saw with the latch high. Holding the latch input high therefore gives plain non-multiplexed addressing.

An arbiter shares the RAM between the host and the engine. An engine transfer holds the RAM for `XFER_CYCLES` clocks. If an engine transfer is already running, the host waits for it to finish. If the host and the engine both want the RAM at a transfer boundary, the host wins. A host cycle therefore waits for at most one engine transfer. The block acts only as a slave and never drives the host bus as a master.

Top module: `host_share_if`

## Requirements
- R1: The read/write line `rdWr` reads when its level equals the polarity strap latched at reset, and writes otherwise. With the strap at 1, high means read. With the strap at 0, low means read.
- R2: In handshaked mode (handshake strap 1 at reset), every completed host cycle gives exactly one clock of `hostReady` high. With the RAM free, ready is high in the second clock after the clock edge that first samples the strobe low.
- R3: In zero-wait mode (handshake strap 0 at reset), `hostReady` never goes high. Reads and writes still take effect, and read data is on `dataOut` two edges after the strobe is sampled.
- R4: `memSel` = 1 sends the cycle to the RAM, using address bits [RAM_AW-1:0]. `memSel` = 0 sends it to the registers, using address bits [3:0] of 16 registers that reset to 0. The two spaces are separate, so the same address in one space does not change the other.
- R5: While `addrLatch` is high, the cycle uses `addrIn` directly. While it is low, the cycle uses the value `addrIn` had in the last clock in which `addrLatch` was high.
- R6: A host RAM cycle waits for at most one engine transfer. In the worst case, the engine starts a transfer on the same edge that captures the host strobe, and ready then arrives XFER_CYCLES+1 edges after capture.
- R7: An engine transfer keeps the RAM only while it is running. If a host RAM request and an engine request are both pending at a transfer boundary, the host is granted first.
- R8: After a read completes, `dataOe` stays high and `dataOut` stays stable until the strobe is sampled high. `dataOe` is low one edge after that.
- R9: `mstClr` high for one clock sends the handshake logic and the arbiter back to idle. `hostReady`, `dataOe` and `engAck` go low, and a pending host cycle is dropped, so the next cycle sees a free RAM.
- R10: The polarity and handshake straps are sampled only while `rstN` is low. Changes on the strap pins after reset have no effect.
- R11: When granted, an engine request gives a one-clock `engAck` on the edge after the grant. On a read, `engRdata` holds the RAM word at that point. An engine write becomes visible to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also the strap sampling window |
| mstClr | input | 1 | Synchronous master clear of the handshake logic and the arbiter |
| strapRdPol | input | 1 | Read/write polarity strap |
| strapHandshake | input | 1 | 1 = handshaked (ready) mode, 0 = zero-wait mode |
| strbN | input | 1 | Active-low host cycle strobe |
| rdWr | input | 1 | Host read/write line, sense set by the polarity strap |
| memSel | input | 1 | 1 = RAM, 0 = registers |
| addrLatch | input | 1 | Address latch enable; tie high for non-multiplexed buses |
| addrIn | input | 16 | Host address |
| dataIn | input | 16 | Host write data |
| dataOut | output | 16 | Host read data |
| dataOe | output | 1 | Read data drive enable |
| hostReady | output | 1 | One-clock cycle-complete pulse (handshaked mode) |
| engReq | input | 1 | Engine transfer request |
| engWe | input | 1 | Engine write (1) or read (0) |
| engAddr | input | RAM_AW | Engine RAM address |
| engWdata | input | 16 | Engine write data |
| engRdata | output | 16 | Engine read data, valid with engAck |
| engAck | output | 1 | One-clock engine grant pulse |

## Verification
The bench drives inputs and samples outputs on falling edges and counts the rising edges from the strobe until ready. The expected count is 2 for an idle RAM or a register, XFER_CYCLES when the engine started one edge earlier, and XFER_CYCLES+1 when the engine starts on the capture edge itself. The ready pulse is checked one edge later for being low. `dataOe` is checked while the strobe is still held and again one edge after release. `engAck` is expected one edge after `engReq` rises on an idle arbiter. In zero-wait mode, read data is sampled at the third falling edge after the strobe, with ready watched the whole time.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_HOLD = 2'd2
  } hostState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch address, data, direction, space
    logic regOp;     // perform register access
    logic ramOp;     // perform host RAM access
    logic engStart;  // perform engine RAM access
  } dpStrobe_t;

endpackage

// File: rtl/hsi_arbiter.sv
module hsi_arbiter #(
  parameter int XFER_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic mstClr,
  input  logic engReq,
  input  logic hostWantsRam,
  output logic hostGrant,
  output logic engStart,
  output logic engAck
);
  localparam int CW = $clog2(XFER_CYCLES + 1);

  logic [CW-1:0] xferCnt;
  logic          xferBusy;

  assign xferBusy  = (xferCnt != '0);
  // host wins any boundary; engine only keeps a transfer already running
  assign hostGrant = hostWantsRam && !xferBusy && !mstClr;
  assign engStart  = engReq && !xferBusy && !hostWantsRam && !mstClr;

  always_ff @(posedge clk) begin
    if (!rstN || mstClr) begin
      xferCnt <= '0;
      engAck  <= 1'b0;
    end else begin
      engAck <= engStart;
      if (engStart)
        xferCnt <= CW'(XFER_CYCLES - 1);
      else if (xferBusy)
        xferCnt <= xferCnt - CW'(1);
    end
  end

endmodule

// File: rtl/hsi_control.sv
module hsi_control
  import hsi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mstClr,
  input  logic      strapRdPol,
  input  logic      strapHandshake,
  input  logic      strbN,
  input  logic      opMem,
  input  logic      opRead,
  input  logic      hostGrant,
  input  logic      engStart,
  output dpStrobe_t strb,
  output logic      hostWantsRam,
  output logic      polSel,
  output logic      nzwMode,
  output logic      hostReady,
  output logic      dataOe
);
  hostState_t state, nextState;

  assign hostWantsRam = !mstClr && (state == HS_REQ) && opMem;
  assign dataOe       = (state == HS_HOLD) && opRead;

  always_comb begin
    nextState     = state;
    strb          = '0;
    strb.engStart = engStart;
    if (!mstClr) begin
      case (state)
        HS_IDLE: if (!strbN) begin
          strb.capture = 1'b1;
          nextState    = HS_REQ;
        end
        HS_REQ: begin
          if (!opMem) begin
            strb.regOp = 1'b1;
            nextState  = HS_HOLD;
          end else if (hostGrant) begin
            strb.ramOp = 1'b1;
            nextState  = HS_HOLD;
          end
        end
        HS_HOLD: if (strbN) nextState = HS_IDLE;
        default: nextState = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polSel    <= strapRdPol;
      nzwMode   <= strapHandshake;
      state     <= HS_IDLE;
      hostReady <= 1'b0;
    end else if (mstClr) begin
      state     <= HS_IDLE;
      hostReady <= 1'b0;
    end else begin
      state     <= nextState;
      hostReady <= nzwMode && (strb.regOp || strb.ramOp);
    end
  end

endmodule

// File: rtl/hsi_datapath.sv
module hsi_datapath
  import hsi_pkg::*;
#(
  parameter int DW       = 16,
  parameter int HAW      = 16,
  parameter int RAM_AW   = 12,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              polSel,
  input  logic              rdWr,
  input  logic              memSel,
  input  logic              addrLatch,
  input  logic [HAW-1:0]    addrIn,
  input  logic [DW-1:0]     dataIn,
  input  logic              engWe,
  input  logic [RAM_AW-1:0] engAddr,
  input  logic [DW-1:0]     engWdata,
  output logic              opMem,
  output logic              opRead,
  output logic [DW-1:0]     hostRdata,
  output logic [DW-1:0]     engRdata
);
  localparam int REG_AW    = $clog2(NUM_REGS);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [HAW-1:0]    addrHold, effAddr;
  logic [RAM_AW-1:0] opAddr;
  logic [DW-1:0]     opWdata;
  logic [DW-1:0]     regFile [NUM_REGS];
  logic [DW-1:0]     ram [RAM_DEPTH];
  logic [RAM_AW-1:0] ramAddr;
  logic [DW-1:0]     ramWd;
  logic              ramWe;
  logic [REG_AW-1:0] regIdx;
  logic              unusedAddrBits;

  // address latch: transparent while high, holds while low
  always_ff @(posedge clk) begin
    if (!rstN)          addrHold <= '0;
    else if (addrLatch) addrHold <= addrIn;
  end
  assign effAddr        = addrLatch ? addrIn : addrHold;
  assign unusedAddrBits = ^effAddr[HAW-1:RAM_AW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr  <= '0;
      opWdata <= '0;
      opMem   <= 1'b0;
      opRead  <= 1'b0;
    end else if (strb.capture) begin
      opAddr  <= effAddr[RAM_AW-1:0];
      opWdata <= dataIn;
      opMem   <= memSel;
      opRead  <= (rdWr == polSel);
    end
  end

  assign regIdx = opAddr[REG_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strb.regOp && !opRead) begin
      regFile[regIdx] <= opWdata;
    end
  end

  // single RAM port, engine and host never strobed together
  assign ramAddr = strb.engStart ? engAddr  : opAddr;
  assign ramWd   = strb.engStart ? engWdata : opWdata;
  assign ramWe   = strb.engStart ? engWe    : (strb.ramOp && !opRead);

  always_ff @(posedge clk) begin
    if (ramWe) ram[ramAddr] <= ramWd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
      engRdata  <= '0;
    end else begin
      if (strb.engStart && !engWe)
        engRdata <= ram[ramAddr];
      if (strb.ramOp && opRead)
        hostRdata <= ram[ramAddr];
      else if (strb.regOp && opRead)
        hostRdata <= regFile[regIdx];
    end
  end

endmodule

// File: rtl/host_share_if.sv
module host_share_if
  import hsi_pkg::*;
#(
  parameter int RAM_AW      = 12,
  parameter int NUM_REGS    = 16,
  parameter int XFER_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mstClr,
  input  logic              strapRdPol,
  input  logic              strapHandshake,
  input  logic              strbN,
  input  logic              rdWr,
  input  logic              memSel,
  input  logic              addrLatch,
  input  logic [15:0]       addrIn,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  output logic              hostReady,
  input  logic              engReq,
  input  logic              engWe,
  input  logic [RAM_AW-1:0] engAddr,
  input  logic [15:0]       engWdata,
  output logic [15:0]       engRdata,
  output logic              engAck
);
  dpStrobe_t strb;
  logic hostWantsRam, hostGrant, engStart;
  logic polSel, nzwMode, opMem, opRead;

  hsi_control uCtrl (
    .clk(clk), .rstN(rstN), .mstClr(mstClr),
    .strapRdPol(strapRdPol), .strapHandshake(strapHandshake),
    .strbN(strbN), .opMem(opMem), .opRead(opRead),
    .hostGrant(hostGrant), .engStart(engStart),
    .strb(strb), .hostWantsRam(hostWantsRam),
    .polSel(polSel), .nzwMode(nzwMode),
    .hostReady(hostReady), .dataOe(dataOe)
  );

  hsi_arbiter #(.XFER_CYCLES(XFER_CYCLES)) uArb (
    .clk(clk), .rstN(rstN), .mstClr(mstClr),
    .engReq(engReq), .hostWantsRam(hostWantsRam),
    .hostGrant(hostGrant), .engStart(engStart), .engAck(engAck)
  );

  hsi_datapath #(
    .DW(16), .HAW(16), .RAM_AW(RAM_AW), .NUM_REGS(NUM_REGS)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .polSel(polSel),
    .rdWr(rdWr), .memSel(memSel), .addrLatch(addrLatch),
    .addrIn(addrIn), .dataIn(dataIn),
    .engWe(engWe), .engAddr(engAddr), .engWdata(engWdata),
    .opMem(opMem), .opRead(opRead),
    .hostRdata(dataOut), .engRdata(engRdata)
  );

endmodule

// File: rtl/hsi_chk.sv
module hsi_chk #(
  parameter int XFER_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        mstClr,
  input logic        hostReady,
  input logic        dataOe,
  input logic [15:0] dataOut,
  input logic        engAck,
  input logic        hostWaiting,
  input logic        nzwMode,
  input logic        polSel
);
  int waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !hostWaiting) waitCnt <= 0;
    else                       waitCnt <= waitCnt + 1;
  end

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  // R3
  zero_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nzwMode |-> !hostReady);

  // R6
  holdoff_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= XFER_CYCLES);

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    mstClr |=> (!hostReady && !dataOe && !engAck));

  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(nzwMode) && $stable(polSel));

  // R11
  eng_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    engAck |=> !engAck);

endmodule

bind host_share_if hsi_chk #(.XFER_CYCLES(XFER_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .mstClr(mstClr),
  .hostReady(hostReady), .dataOe(dataOe), .dataOut(dataOut),
  .engAck(engAck), .hostWaiting(hostWantsRam),
  .nzwMode(nzwMode), .polSel(polSel)
);

// File: tb/host_share_if_test.sv
`timescale 1ns/1ps
module host_share_if_test;
  localparam int XFER = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, mstClr = 1'b0;
  logic strapRdPol = 1'b1, strapHandshake = 1'b1;
  logic strbN = 1'b1, rdWr = 1'b0, memSel = 1'b0, addrLatch = 1'b1;
  logic [15:0] addrIn = '0, dataIn = '0;
  logic [15:0] dataOut, engRdata;
  logic dataOe, hostReady, engAck;
  logic engReq = 1'b0, engWe = 1'b0;
  logic [11:0] engAddr = '0;
  logic [15:0] engWdata = '0;

  int checks = 0, failures = 0;
  bit benchPol = 1'b1;
  logic [15:0] ramModel [64];
  logic [15:0] regModel [16];

  always #2 clk = ~clk;

  host_share_if #(.RAM_AW(12), .NUM_REGS(16), .XFER_CYCLES(XFER)) uut (
    .clk(clk), .rstN(rstN), .mstClr(mstClr),
    .strapRdPol(strapRdPol), .strapHandshake(strapHandshake),
    .strbN(strbN), .rdWr(rdWr), .memSel(memSel), .addrLatch(addrLatch),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .hostReady(hostReady), .engReq(engReq), .engWe(engWe),
    .engAddr(engAddr), .engWdata(engWdata), .engRdata(engRdata),
    .engAck(engAck)
  );

  function automatic logic [15:0] initWord(input int a);
    return 16'((a * 40503) ^ 16'h5A5A);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit pol, input bit hs);
    strapRdPol = pol; strapHandshake = hs; benchPol = pol;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) regModel[i] = '0;
    @(negedge clk);
  endtask

  // handshaked host cycle; returns edges to ready and read data
  task automatic hostNzw(input bit mem, input bit rd, input logic [15:0] a,
                         input logic [15:0] wd, input bit muxed,
                         output logic [15:0] rdv, output int n);
    logic [15:0] first;
    strbN = 1'b0; memSel = mem; rdWr = rd ? benchPol : !benchPol;
    dataIn = wd;
    if (!muxed) begin addrLatch = 1'b1; addrIn = a; end
    n = 0;
    while (!hostReady && n < 20) begin @(negedge clk); n++; end
    rdv = dataOut; first = dataOut;
    @(negedge clk);
    check("R2 ready one clock", {31'd0, hostReady}, 32'd0);
    if (rd) begin
      check("R8 oe held with strobe", {31'd0, dataOe}, 32'd1);
      check("R8 data stable", {16'd0, dataOut}, {16'd0, first});
    end
    strbN = 1'b1;
    @(negedge clk);
    check("R8 oe off after release", {31'd0, dataOe}, 32'd0);
    if (mem && !rd && a < 64) ramModel[a] = wd;
    if (!mem && !rd) regModel[a[3:0]] = wd;
  endtask

  task automatic hostZw(input bit mem, input bit rd, input logic [15:0] a,
                        input logic [15:0] wd, output logic [15:0] rdv);
    bit seen = 1'b0;
    strbN = 1'b0; memSel = mem; rdWr = rd ? benchPol : !benchPol;
    dataIn = wd; addrLatch = 1'b1; addrIn = a;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (hostReady) seen = 1'b1;
    end
    rdv = dataOut;
    strbN = 1'b1;
    @(negedge clk);
    if (hostReady) seen = 1'b1;
    check("R3 no ready in zero-wait", {31'd0, seen}, 32'd0);
  endtask

  task automatic engXfer(input bit we, input logic [11:0] a,
                         input logic [15:0] wd, input bit dropReq,
                         output logic [15:0] rdv, output int n);
    engReq = 1'b1; engWe = we; engAddr = a; engWdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!engAck && n < 20);
    rdv = engRdata;
    if (dropReq) engReq = 1'b0;
    if (we && a < 64) ramModel[a] = wd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rv, ev;
    int n, ne;
    void'($urandom(32'd20240611));

    doReset(1'b1, 1'b1);
    check("R9 reset ready low", {31'd0, hostReady}, 32'd0);
    check("R9 reset oe low", {31'd0, dataOe}, 32'd0);
    check("R9 reset engAck low", {31'd0, engAck}, 32'd0);

    for (int a = 0; a < 64; a++) hostNzw(1, 0, 16'(a), initWord(a), 0, rv, n);
    hostNzw(1, 0, 16'h0FFF, 16'h0000, 0, rv, n);

    // R1 / R2: write then read RAM, polarity high means read
    hostNzw(1, 0, 16'd5, 16'hA5A5, 0, rv, n);
    check("R2 write ready edges", n, 2);
    hostNzw(1, 1, 16'd5, 16'h0, 0, rv, n);
    check("R2 read ready edges", n, 2);
    check("R1 read with polarity 1", {16'd0, rv}, 32'hA5A5);

    // R4 register space separate from RAM
    hostNzw(0, 1, 16'd5, 16'h0, 0, rv, n);
    check("R4 register resets to 0", {16'd0, rv}, 32'h0);
    hostNzw(0, 0, 16'd5, 16'h1234, 0, rv, n);
    check("R4 register write ready edges", n, 2);
    hostNzw(0, 1, 16'd5, 16'h0, 0, rv, n);
    check("R4 register readback", {16'd0, rv}, 32'h1234);
    hostNzw(1, 1, 16'd5, 16'h0, 0, rv, n);
    check("R4 RAM untouched by register write", {16'd0, rv}, 32'hA5A5);

    // R5 multiplexed address latch
    addrLatch = 1'b1; addrIn = 16'd7;
    @(negedge clk);
    addrLatch = 1'b0; addrIn = 16'h0FFF;
    hostNzw(1, 0, 16'd7, 16'hC0DE, 1, rv, n);
    addrLatch = 1'b1;
    hostNzw(1, 1, 16'd7, 16'h0, 0, rv, n);
    check("R5 latched address used", {16'd0, rv}, 32'hC0DE);
    hostNzw(1, 1, 16'h0FFF, 16'h0, 0, rv, n);
    check("R5 bus address ignored while latched", {16'd0, rv}, 32'h0);

    // R10 strap pins changed after reset
    strapRdPol = 1'b0; strapHandshake = 1'b0;
    hostNzw(1, 1, 16'd5, 16'h0, 0, rv, n);
    check("R10 handshake kept", n, 2);
    check("R10 polarity kept", {16'd0, rv}, 32'hA5A5);

    // R11 engine write seen by host, host write seen by engine
    engXfer(1, 12'd9, 16'hBEEF, 1, rv, ne);
    check("R11 engAck one edge after request", ne, 1);
    @(negedge clk);
    check("R11 engAck one clock", {31'd0, engAck}, 32'd0);
    repeat (XFER) @(negedge clk);
    hostNzw(1, 1, 16'd9, 16'h0, 0, rv, n);
    check("R11 engine write visible", {16'd0, rv}, 32'hBEEF);
    hostNzw(1, 0, 16'd10, 16'h1357, 0, rv, n);
    engXfer(0, 12'd10, 16'h0, 1, rv, ne);
    check("R11 engine read data", {16'd0, rv}, 32'h1357);

    // R6 host right behind a running transfer
    hostNzw(1, 1, 16'd9, 16'h0, 0, rv, n);
    check("R6 wait behind transfer started one edge earlier", n, XFER);
    check("R6 data after wait", {16'd0, rv}, 32'hBEEF);

    // R6 worst case: engine starts on the capture edge
    fork
      engXfer(0, 12'd5, 16'h0, 1, ev, ne);
      hostNzw(1, 1, 16'd10, 16'h0, 0, rv, n);
    join
    check("R6 worst-case holdoff", n, XFER + 1);
    check("R11 engine read under contention", {16'd0, ev}, 32'hA5A5);

    // R7 engine keeps requesting: host still wins the boundary
    repeat (XFER) @(negedge clk);
    engReq = 1'b1; engWe = 1'b0; engAddr = 12'd5;
    hostNzw(1, 1, 16'd9, 16'h0, 0, rv, n);
    check("R7 host granted at boundary", n, XFER + 1);
    engReq = 1'b0;
    repeat (XFER + 1) @(negedge clk);

    // R9 master clear mid-wait
    engReq = 1'b1; engAddr = 12'd5;
    strbN = 1'b0; memSel = 1'b1; rdWr = benchPol; addrIn = 16'd9;
    repeat (2) @(negedge clk);
    mstClr = 1'b1; strbN = 1'b1; engReq = 1'b0;
    @(negedge clk);
    mstClr = 1'b0;
    begin
      bit bad = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (hostReady || dataOe || engAck) bad = 1'b1;
        @(negedge clk);
      end
      check("R9 cleared cycle dropped", {31'd0, bad}, 32'd0);
    end
    hostNzw(1, 1, 16'd10, 16'h0, 0, rv, n);
    check("R9 arbiter idle after clear", n, 2);

    // random mix against model
    for (int it = 0; it < 60; it++) begin
      bit mem = 1'($urandom);
      bit rd  = 1'($urandom);
      logic [15:0] a = mem ? 16'($urandom % 64) : 16'($urandom % 16);
      logic [15:0] w = 16'($urandom);
      ev = mem ? ramModel[a] : regModel[a[3:0]];
      hostNzw(mem, rd, a, w, 0, rv, n);
      check("R2 random ready edges", n, 2);
      if (rd) check("R4 random readback", {16'd0, rv}, {16'd0, ev});
    end

    // R3 zero-wait with reversed polarity
    doReset(1'b0, 1'b0);
    hostZw(1, 0, 16'd20, 16'h4242, rv);
    hostZw(1, 1, 16'd20, 16'h0, rv);
    check("R3 zero-wait RAM read", {16'd0, rv}, 32'h4242);
    check("R1 polarity 0 low reads", {16'd0, rv}, 32'h4242);
    hostZw(0, 0, 16'd3, 16'h0F0F, rv);
    hostZw(0, 1, 16'd3, 16'h0, rv);
    check("R3 zero-wait register read", {16'd0, rv}, 32'h0F0F);
    hostZw(1, 1, 16'd5, 16'h0, rv);
    check("R3 RAM kept across reset", {16'd0, rv}, {16'd0, ramModel[5]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule